// File: doc/BRIEF.md
# Mailbox Requester Engine

This block is the host-side master for one data-object mailbox that sits behind a 32-bit register port. A client gives it one task at a time. A task names a protocol by a 16-bit vendor ID and an 8-bit type, says how many request dwords follow, and gives a response capacity in dwords. The engine then does the work in order:

- It checks the mailbox status.
- It writes the two header dwords and streams the request payload into the write mailbox.
- It sets Go.
- It waits for Data Object Ready, either by polling on an interval timer or by waiting for an interrupt pulse.
- It drains the response. Every dword read is acknowledged with a write of zero.

When the task ends, the engine gives one signed result. This is either the number of response bytes delivered or a negative error code.

Request payload comes in on a valid/ready stream (`pl_*`). A dword is taken only when the engine is ready to write it to the mailbox, so a slow producer just stretches the request. Response dwords leave on a valid/ready stream (`rsp_*`). While `rsp_valid` is high and `rsp_ready` is low, the data is held stable and the mailbox is not acknowledged, so the consumer throttles the drain.

The engine recovers from a stuck or busy mailbox on its own:
- **Error abort:** after an error or timeout, it writes Abort and polls until the mailbox is clean.
- **Commanded abort:** the `abort_req` input does the same on request.
- **Dead mailbox:** if a recovery itself times out, the mailbox is marked dead, and every later task is refused with an error.

Top module: `mbx_requester`

## Requirements
- R1: After reset, `task_ready`=1, `bus_req`=0, `done_valid`=0, `rsp_valid`=0 and `dead`=0. A fresh reset also clears a previous dead state.
- R2: Register selects are 0=control, 1=status, 2=write mailbox and 3=read mailbox. Status bits are busy=bit0, error=bit2 and object-ready=bit31. Control bits are abort=bit0, interrupt-enable=bit1 and Go=bit31. An accepted task causes these bus operations in order:
  1. A status read.
  2. A write-mailbox write of `{8'h00, type, vid}`.
  3. A write-mailbox write of the length, which is request dwords + 2.
  4. One write-mailbox write per request dword, in stream order.
  5. A control write of 32'h8000_0000, or 32'h8000_0002 when `use_irq`=1.
- R3: While `bus_req` is high and `bus_ack` is low, `bus_we`, `bus_addr` and `bus_wdata` stay stable and `bus_req` stays high.
- R4: If the pre-send status shows busy, the status read is retried after `BUSY_WAIT_CYC` cycles. After `BUSY_TRIES` busy reads in a row, the task ends with code -16 and no mailbox write is made.
- R5: If the pre-send status shows error (and not busy), the task ends with code -5, and the engine writes control abort (bit0) before it accepts another task.
- R6: The response length field is bits [20:0] of header 2. Every read of the read mailbox is followed by a write of 0 to it.
  - The first min(length-2, capacity) payload dwords go out on `rsp_data`, in order. Further dwords are read and acknowledged but not delivered.
  - The result is 4 × dwords delivered.
  - `rsp_data` stays stable while it is stalled.
- R7: The task ends with code -5 and an error abort when any of these hold:
  - The response header 1 vendor ID (bits [15:0]) or type (bits [23:16]) differs from the task.
  - The length is below 2 or above 2^20.
  - The status read after draining shows error.
- R8: Without interrupts, status is polled every `POLL_CYC` cycles after Go. If object-ready is still clear `TMO_CYC` cycles after Go, the task ends with code -110 and an error abort.
- R9: In recovery, status is polled every `POLL_CYC` cycles. When busy and error are both clear, the engine returns to idle (`task_ready`=1). If they are not clear within `TMO_CYC` cycles of the abort write, `dead` goes high and stays high.
- R10: While `dead`=1, an accepted task ends with `done_valid` high in the next cycle, with code -5, and makes no bus operation.
- R11: A pulse on `abort_req` while a task waits for its response makes the engine write control abort. The task ends with code -14 once recovery finishes.
- R12: With `use_irq`=1, no status read happens after Go until `mb_irq` pulses (or the timeout expires). After the pulse, the response is collected normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_irq | input | 1 | 1: wait for the interrupt pulse; 0: poll status |
| mb_irq | input | 1 | Mailbox interrupt pulse |
| abort_req | input | 1 | Commanded abort pulse |
| task_valid | input | 1 | Task descriptor valid |
| task_ready | output | 1 | Engine idle and able to take a task |
| task_vid | input | 16 | Protocol vendor ID |
| task_type | input | 8 | Protocol type |
| task_req_dw | input | CNT_W | Request payload dwords |
| task_rsp_cap | input | CNT_W | Response capacity in dwords |
| pl_valid | input | 1 | Request payload dword valid |
| pl_ready | output | 1 | Engine takes the payload dword |
| pl_data | input | 32 | Request payload dword |
| rsp_valid | output | 1 | Response dword valid |
| rsp_ready | input | 1 | Consumer takes the response dword |
| rsp_data | output | 32 | Response payload dword |
| done_valid | output | 1 | One-cycle task completion pulse |
| done_code | output | 32 | Signed result: byte count, or -16, -5, -110 or -14 |
| dead | output | 1 | Mailbox declared unusable |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1: write, 0: read |
| bus_addr | output | 2 | Register select |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete, with read data |
| bus_rdata | input | 32 | Read data |

## Verification
A wrong step register shows on the register port within one access. The next operation then has the wrong select, data or order in the logged write sequence, or it skips a zero-acknowledge, which leaves the mailbox's read pointer short of the response length. A wrong phase or a stuck flag shows as a wrong signed code on `done_code` when the task completes. It can also show as `task_ready` failing to come back within a few poll intervals of recovery. A dead flag that is set or cleared in error shows on the very next task, because a dead engine answers in one cycle with no bus traffic.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE, PH_WAIT_RESP, PH_WAIT_ABORT, PH_WAIT_ABORT_ERR
  } mbx_phase_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK_STAT, S_BACKOFF, S_HDR1, S_HDR2, S_PAY, S_GO,
    S_WAIT, S_RSTAT, S_RH1, S_RA1, S_RH2, S_RA2, S_RD, S_OUT,
    S_RCHK, S_RACK, S_FSTAT, S_ABT_WR, S_ABT_WAIT, S_ABT_STAT
  } mbx_step_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_WBOX = 2'd2;
  localparam logic [1:0] A_RBOX = 2'd3;

  localparam int ST_BUSY  = 0;
  localparam int ST_ERR   = 2;
  localparam int ST_READY = 31;

  localparam logic signed [31:0] RC_BUSY    = -32'sd16;
  localparam logic signed [31:0] RC_IO      = -32'sd5;
  localparam logic signed [31:0] RC_TMO     = -32'sd110;
  localparam logic signed [31:0] RC_ABORTED = -32'sd14;

endpackage

// File: rtl/mbx_countdown.sv
module mbx_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mbx_rsp_hdr.sv
module mbx_rsp_hdr #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 21
) (
  input  logic [31:0]      word,
  input  logic [15:0]      exp_vid,
  input  logic [7:0]       exp_type,
  input  logic [CNT_W-1:0] cap,
  output logic             id_ok,
  output logic             len_ok,
  output logic [LEN_W-1:0] rem,
  output logic [LEN_W-1:0] keep
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << (LEN_W - 1);
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] cap_x;

  assign len    = word[LEN_W-1:0];
  assign cap_x  = LEN_W'(cap);
  assign id_ok  = (word[15:0] == exp_vid) && (word[23:16] == exp_type);
  assign len_ok = (len >= LEN_W'(2)) && (len <= MAX_LEN);
  assign rem    = len - LEN_W'(2);
  assign keep   = (rem < cap_x) ? rem : cap_x;
endmodule

// File: rtl/mbx_requester.sv
module mbx_requester
  import mbx_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int LEN_W         = 21,
  parameter int TMO_CYC       = 250_000_000,
  parameter int POLL_CYC      = TMO_CYC / 128,
  parameter int BUSY_WAIT_CYC = TMO_CYC / 16,
  parameter int BUSY_TRIES    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    use_irq,
  input  logic                    mb_irq,
  input  logic                    abort_req,
  input  logic                    task_valid,
  output logic                    task_ready,
  input  logic [15:0]             task_vid,
  input  logic [7:0]              task_type,
  input  logic [CNT_W-1:0]        task_req_dw,
  input  logic [CNT_W-1:0]        task_rsp_cap,
  input  logic                    pl_valid,
  output logic                    pl_ready,
  input  logic [31:0]             pl_data,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [31:0]             rsp_data,
  output logic                    done_valid,
  output logic signed [31:0]      done_code,
  output logic                    dead,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [1:0]              bus_addr,
  output logic [31:0]             bus_wdata,
  input  logic                    bus_ack,
  input  logic [31:0]             bus_rdata
);
  localparam int TMO_W  = $clog2(TMO_CYC + 1);
  localparam int IV_MAX = (POLL_CYC > BUSY_WAIT_CYC) ? POLL_CYC : BUSY_WAIT_CYC;
  localparam int IV_W   = $clog2(IV_MAX + 1);
  localparam int TRY_W  = $clog2(BUSY_TRIES + 1);

  mbx_phase_e        phase;
  mbx_step_e         step;
  logic [15:0]       cmd_vid;
  logic [7:0]        cmd_type;
  logic [CNT_W-1:0]  cmd_req_dw, cmd_cap;
  logic [LEN_W-1:0]  cnt, rem, keep;
  logic [TRY_W-1:0]  tries;
  logic              task_live, abort_pend, irq_pend;

  logic              ack, st_busy, st_err, st_ready;
  logic              iv_load, to_load, iv_exp, to_exp;
  logic [IV_W-1:0]   iv_val;
  logic              id_ok, len_ok, fail;
  logic [LEN_W-1:0]  h_rem, h_keep;
  logic signed [31:0] fail_code;

  assign ack      = bus_req && bus_ack;
  assign st_busy  = bus_rdata[ST_BUSY];
  assign st_err   = bus_rdata[ST_ERR];
  assign st_ready = bus_rdata[ST_READY];

  assign task_ready = (step == S_IDLE) && !abort_pend;
  assign pl_ready   = (step == S_PAY) && !bus_req;

  mbx_countdown #(.W(IV_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .load(iv_load), .load_val(iv_val), .expired(iv_exp));

  mbx_countdown #(.W(TMO_W)) u_timeout (
    .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TMO_W'(TMO_CYC)), .expired(to_exp));

  mbx_rsp_hdr #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_hdr (
    .word(bus_rdata), .exp_vid(cmd_vid), .exp_type(cmd_type), .cap(cmd_cap),
    .id_ok(id_ok), .len_ok(len_ok), .rem(h_rem), .keep(h_keep));

  // failures that send the engine into error recovery
  always_comb begin
    fail      = 1'b0;
    fail_code = RC_IO;
    if (ack) begin
      unique case (step)
        S_CHK_STAT: fail = st_err && !st_busy;
        S_RSTAT: begin
          if (st_err) fail = 1'b1;
          else if (!st_ready && to_exp) begin fail = 1'b1; fail_code = RC_TMO; end
        end
        S_RH1:   fail = !id_ok;
        S_RH2:   fail = !len_ok;
        S_RCHK:  fail = !st_ready;
        S_FSTAT: fail = st_err;
        default: fail = 1'b0;
      endcase
    end
  end

  // timer loads
  always_comb begin
    iv_load = 1'b0;
    iv_val  = IV_W'(POLL_CYC);
    to_load = 1'b0;
    if (ack) begin
      unique case (step)
        S_CHK_STAT: if (st_busy && tries != TRY_W'(BUSY_TRIES - 1)) begin
          iv_load = 1'b1; iv_val = IV_W'(BUSY_WAIT_CYC);
        end
        S_GO, S_ABT_WR: begin iv_load = 1'b1; to_load = 1'b1; end
        S_RSTAT:    iv_load = !fail && !st_ready;
        S_ABT_STAT: iv_load = (st_busy || st_err) && !to_exp;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  step <= S_IDLE;
      cmd_vid <= '0; cmd_type <= '0; cmd_req_dw <= '0; cmd_cap <= '0;
      cnt <= '0; rem <= '0; keep <= '0; tries <= '0;
      task_live <= 1'b0; abort_pend <= 1'b0; irq_pend <= 1'b0; dead <= 1'b0;
      bus_req <= 1'b0; bus_we <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0; done_valid <= 1'b0; done_code <= '0;
    end else begin
      done_valid <= 1'b0;
      if (mb_irq)    irq_pend   <= 1'b1;
      if (abort_req) abort_pend <= 1'b1;
      if (ack)       bus_req    <= 1'b0;
      if (fail) begin
        done_valid <= 1'b1;  done_code <= fail_code;  task_live <= 1'b0;
        phase <= PH_WAIT_ABORT_ERR;  step <= S_ABT_WR;
      end else begin
        unique case (step)
          S_IDLE: begin
            if (abort_pend) begin
              abort_pend <= 1'b0;  phase <= PH_WAIT_ABORT;  step <= S_ABT_WR;
            end else if (task_valid) begin
              cmd_vid <= task_vid;  cmd_type <= task_type;
              cmd_req_dw <= task_req_dw;  cmd_cap <= task_rsp_cap;
              if (dead) begin
                done_valid <= 1'b1;  done_code <= RC_IO;
              end else begin
                task_live <= 1'b1;  tries <= '0;  step <= S_CHK_STAT;
              end
            end
          end
          S_BACKOFF: if (iv_exp) step <= S_CHK_STAT;
          S_CHK_STAT: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b0; bus_addr <= A_STAT;
            end else if (bus_ack) begin
              if (!st_busy) step <= S_HDR1;
              else if (tries == TRY_W'(BUSY_TRIES - 1)) begin
                done_valid <= 1'b1;  done_code <= RC_BUSY;
                task_live <= 1'b0;  step <= S_IDLE;
              end else begin
                tries <= tries + 1'b1;  step <= S_BACKOFF;
              end
            end
          end
          S_HDR1: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_WBOX;
              bus_wdata <= {8'h00, cmd_type, cmd_vid};
            end else if (bus_ack) step <= S_HDR2;
          end
          S_HDR2: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_WBOX;
              bus_wdata <= 32'(cmd_req_dw) + 32'd2;
            end else if (bus_ack) begin
              cnt  <= '0;
              step <= (cmd_req_dw != '0) ? S_PAY : S_GO;
            end
          end
          S_PAY: begin
            if (!bus_req) begin
              if (pl_valid) begin
                bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_WBOX; bus_wdata <= pl_data;
              end
            end else if (bus_ack) begin
              cnt <= cnt + 1'b1;
              if (cnt == LEN_W'(cmd_req_dw) - 1'b1) step <= S_GO;
            end
          end
          S_GO: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_CTRL;
              bus_wdata <= {1'b1, 29'd0, use_irq, 1'b0};
            end else if (bus_ack) begin
              phase <= PH_WAIT_RESP;  irq_pend <= 1'b0;  step <= S_WAIT;
            end
          end
          S_WAIT: begin
            if (abort_pend) begin
              abort_pend <= 1'b0;  phase <= PH_WAIT_ABORT;  step <= S_ABT_WR;
            end else if (use_irq ? (irq_pend || to_exp) : iv_exp) begin
              irq_pend <= 1'b0;  step <= S_RSTAT;
            end
          end
          S_RSTAT, S_RCHK, S_FSTAT: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b0; bus_addr <= A_STAT;
            end else if (bus_ack) begin
              if (step == S_RSTAT) step <= st_ready ? S_RH1 : S_WAIT;
              else if (step == S_RCHK) step <= S_RACK;
              else begin
                done_valid <= 1'b1;  done_code <= 32'(keep) <<< 2;
                task_live <= 1'b0;  phase <= PH_IDLE;  step <= S_IDLE;
              end
            end
          end
          S_RH1, S_RH2, S_RD: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b0; bus_addr <= A_RBOX;
            end else if (bus_ack) begin
              if (step == S_RH1) step <= S_RA1;
              else if (step == S_RH2) begin
                rem <= h_rem;  keep <= h_keep;  cnt <= '0;  step <= S_RA2;
              end else if (cnt < keep) begin
                rsp_valid <= 1'b1;  rsp_data <= bus_rdata;  step <= S_OUT;
              end else step <= S_RACK;
            end
          end
          S_OUT: if (rsp_ready) begin
            rsp_valid <= 1'b0;
            step <= (cnt == keep - 1'b1) ? S_RCHK : S_RACK;
          end
          S_RA1, S_RA2, S_RACK: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_RBOX; bus_wdata <= '0;
            end else if (bus_ack) begin
              if (step == S_RA1) step <= S_RH2;
              else if (step == S_RA2) step <= (rem == '0) ? S_FSTAT : S_RD;
              else begin
                cnt  <= cnt + 1'b1;
                step <= (cnt == rem - 1'b1) ? S_FSTAT : S_RD;
              end
            end
          end
          S_ABT_WR: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b1; bus_addr <= A_CTRL;
              bus_wdata <= {30'd0, use_irq, 1'b1};
            end else if (bus_ack) step <= S_ABT_WAIT;
          end
          S_ABT_WAIT: if (iv_exp) step <= S_ABT_STAT;
          S_ABT_STAT: begin
            if (!bus_req) begin
              bus_req <= 1'b1; bus_we <= 1'b0; bus_addr <= A_STAT;
            end else if (bus_ack) begin
              if ((!st_busy && !st_err) || to_exp) begin
                if (st_busy || st_err) dead <= 1'b1;
                if (phase == PH_WAIT_ABORT && task_live) begin
                  done_valid <= 1'b1;  done_code <= RC_ABORTED;
                end
                task_live <= 1'b0;  phase <= PH_IDLE;  step <= S_IDLE;
              end else step <= S_ABT_WAIT;
            end
          end
          default: step <= S_IDLE;
        endcase
      end
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R3

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)); // R6

  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead); // R9

  AST_DEAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    dead && task_valid && task_ready |=> done_valid && done_code == RC_IO); // R10

  AST_NO_GO_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> !(bus_req && bus_we && bus_addr == A_CTRL && bus_wdata[31])); // R10

endmodule

// File: tb/tb_mbx_requester.sv
module tb_mbx_requester;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_irq = 1'b0, mb_irq = 1'b0, abort_req = 1'b0;
  logic task_valid = 1'b0, task_ready;
  logic [15:0] task_vid = '0;
  logic [7:0]  task_type = '0;
  logic [7:0]  task_req_dw = '0, task_rsp_cap = '0;
  logic pl_valid = 1'b0, pl_ready;
  logic [31:0] pl_data = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic done_valid, dead;
  logic signed [31:0] done_code;
  logic bus_req, bus_we;
  logic [1:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  mbx_requester #(.TMO_CYC(400), .POLL_CYC(8), .BUSY_WAIT_CYC(16)) dut (
    .clk(clk), .rst_n(rst_n), .use_irq(use_irq), .mb_irq(mb_irq), .abort_req(abort_req),
    .task_valid(task_valid), .task_ready(task_ready), .task_vid(task_vid),
    .task_type(task_type), .task_req_dw(task_req_dw), .task_rsp_cap(task_rsp_cap),
    .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_code(done_code), .dead(dead),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int total = 0, bad = 0, done_seen = 0, cyc = 0;
  bit finished = 1'b0;
  int exp_code_q[$];
  logic [31:0] exp_rsp_q[$];
  logic [31:0] pl_q[$];

  // mailbox model state
  int busy_left = 0, abort_busy = 0, ready_delay = 0, go_age = 0, ptr = 0;
  int ops = 0, stat_since_go = 0, abort_writes = 0;
  bit err_flag = 0, err_final = 0, ready_on = 0, going = 0;
  logic [31:0] rsp_mem[$];
  logic [31:0] wlog[$];
  logic [31:0] last_ctrl = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // mailbox model, acts at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (going) begin
      go_age++;
      if (ready_delay >= 0 && go_age >= ready_delay) ready_on = 1'b1;
    end
    if (bus_ack) bus_ack = 1'b0;
    else if (bus_req) begin
      ops++;
      bus_ack = 1'b1;
      case (bus_addr)
        2'd0: if (bus_we) begin
          last_ctrl = bus_wdata;
          if (bus_wdata[31]) begin go_age = 0; ready_on = 0; going = 1; stat_since_go = 0; end
          if (bus_wdata[0]) begin
            abort_writes++; err_flag = 0; going = 0; ready_on = 0; ptr = 0; busy_left = abort_busy;
          end
        end
        2'd1: if (!bus_we) begin
          automatic bit b = (busy_left > 0);
          stat_since_go++;
          if (b) busy_left--;
          bus_rdata = {ready_on && (ptr < rsp_mem.size()), 28'd0, err_flag, 1'b0, b};
        end
        2'd2: if (bus_we) wlog.push_back(bus_wdata);
        default: if (bus_we) begin
          ptr++;
          if (err_final && ptr == rsp_mem.size()) err_flag = 1'b1;
        end else bus_rdata = (ptr < rsp_mem.size()) ? rsp_mem[ptr] : 32'd0;
      endcase
    end
  end

  // payload feeder
  initial forever begin
    automatic bit f;
    @(negedge clk);
    f = pl_valid && pl_ready;
    @(posedge clk); #1;
    if (f) void'(pl_q.pop_front());
    pl_valid = (pl_q.size() > 0);
    pl_data  = (pl_q.size() > 0) ? pl_q[0] : 32'd0;
    rsp_ready = (cyc % 3) != 0;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (exp_code_q.size() == 0) check(1'b0, "R1 unexpected done", done_code, 0);
      else begin
        automatic int e = exp_code_q.pop_front();
        check(done_code == e, "R4-R12 done code", done_code, e);
      end
      done_seen++;
    end
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp_q.size() == 0) check(1'b0, "R6 extra response dword", rsp_data, 0);
      else begin
        automatic logic [31:0] e = exp_rsp_q.pop_front();
        check(rsp_data == e, "R6 response data", rsp_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    summary();
  end

  task automatic set_rsp(input logic [15:0] vid, input logic [7:0] typ, input int len, input int n);
    rsp_mem.delete();
    rsp_mem.push_back({8'h00, typ, vid});
    rsp_mem.push_back(32'(len));
    for (int i = 0; i < n; i++) rsp_mem.push_back(32'hB000_0000 + 32'(i));
    ptr = 0;
  endtask

  task automatic run_task(input logic [15:0] vid, input logic [7:0] typ, input int nreq,
                          input int cap, input int exp_code, input int ndeliver);
    automatic int target = done_seen + 1;
    automatic int lim = 0;
    for (int i = 0; i < nreq; i++) pl_q.push_back(32'hA000_0000 + 32'(i));
    for (int i = 0; i < ndeliver; i++) exp_rsp_q.push_back(rsp_mem[2 + i]);
    exp_code_q.push_back(exp_code);
    @(negedge clk);
    task_vid = vid; task_type = typ; task_req_dw = 8'(nreq); task_rsp_cap = 8'(cap);
    task_valid = 1'b1;
    while (!task_ready) @(negedge clk);
    @(negedge clk);
    task_valid = 1'b0;
    while (done_seen < target && lim < 5000) begin @(negedge clk); lim++; end
  endtask

  task automatic wait_idle(input string req);
    automatic int lim = 0;
    while (!task_ready && lim < 2000) begin @(negedge clk); lim++; end
    check(task_ready, req, task_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(task_ready == 1'b1, "R1 task_ready", task_ready, 1);
    check(bus_req == 1'b0,    "R1 bus_req", bus_req, 0);
    check(done_valid == 1'b0, "R1 done_valid", done_valid, 0);
    check(rsp_valid == 1'b0,  "R1 rsp_valid", rsp_valid, 0);
    check(dead == 1'b0,       "R1 dead", dead, 0);

    // R2 / R6 normal polled exchange
    ready_delay = 30;
    set_rsp(16'h1234, 8'h05, 5, 3);
    wlog.delete();
    run_task(16'h1234, 8'h05, 2, 4, 12, 3);
    check(wlog.size() == 4, "R2 write count", wlog.size(), 4);
    if (wlog.size() == 4) begin
      check(wlog[0] == 32'h0005_1234, "R2 header1", wlog[0], 32'h0005_1234);
      check(wlog[1] == 32'd4,         "R2 header2 length", wlog[1], 4);
      check(wlog[2] == 32'hA000_0000, "R2 payload0", wlog[2], 32'hA000_0000);
      check(wlog[3] == 32'hA000_0001, "R2 payload1", wlog[3], 32'hA000_0001);
    end
    check(last_ctrl == 32'h8000_0000, "R2 go word", last_ctrl, 32'h8000_0000);
    check(ptr == 5, "R6 all dwords acknowledged", ptr, 5);

    // R6 truncation
    set_rsp(16'h1234, 8'h05, 7, 5);
    run_task(16'h1234, 8'h05, 1, 2, 8, 2);
    check(ptr == 7, "R6 excess drained", ptr, 7);
    check(exp_rsp_q.size() == 0, "R6 delivered count", exp_rsp_q.size(), 0);

    // R4 busy retry then success, then busy failure
    set_rsp(16'h00AA, 8'h01, 2, 0);
    busy_left = 3;
    run_task(16'h00AA, 8'h01, 0, 1, 0, 0);
    wlog.delete();
    busy_left = 100;
    run_task(16'h00AA, 8'h01, 1, 1, -16, 0);
    check(wlog.size() == 0, "R4 nothing written when busy", wlog.size(), 0);
    busy_left = 0;
    pl_q.delete();
    wait_idle("R4 idle after busy fail");

    // R5 error before send, R9 recovery
    begin
      automatic int aw = abort_writes;
      err_flag = 1'b1; abort_busy = 2;
      run_task(16'h00AA, 8'h01, 0, 1, -5, 0);
      wait_idle("R9 recovery back to idle");
      check(abort_writes == aw + 1, "R5 abort written", abort_writes, aw + 1);
      check(dead == 1'b0, "R9 not dead after clean recovery", dead, 0);
      abort_busy = 0;
    end

    // R7 mismatched vendor, short length, final error
    set_rsp(16'h4321, 8'h05, 3, 1);
    run_task(16'h1234, 8'h05, 0, 2, -5, 0);
    wait_idle("R7 idle after bad id");
    set_rsp(16'h1234, 8'h05, 1, 0);
    run_task(16'h1234, 8'h05, 0, 2, -5, 0);
    wait_idle("R7 idle after bad length");
    set_rsp(16'h1234, 8'h05, 3, 1);
    err_final = 1'b1;
    run_task(16'h1234, 8'h05, 0, 2, -5, 1);
    err_final = 1'b0;
    wait_idle("R7 idle after final error");

    // R8 timeout
    ready_delay = -1;
    run_task(16'h1234, 8'h05, 0, 2, -110, 0);
    wait_idle("R8 idle after timeout");

    // R11 commanded abort while waiting
    begin
      automatic int aw = abort_writes;
      automatic int target = done_seen + 1;
      exp_code_q.push_back(-14);
      @(negedge clk);
      task_vid = 16'h1234; task_type = 8'h05; task_req_dw = 0; task_rsp_cap = 2;
      task_valid = 1'b1;
      while (!task_ready) @(negedge clk);
      @(negedge clk); task_valid = 1'b0;
      repeat (50) @(negedge clk);
      abort_req = 1'b1; @(negedge clk); abort_req = 1'b0;
      repeat (200) @(negedge clk);
      check(done_seen == target, "R11 aborted task completed", done_seen, target);
      check(abort_writes == aw + 1, "R11 abort written", abort_writes, aw + 1);
    end

    // R12 interrupt mode
    use_irq = 1'b1; ready_delay = 5;
    set_rsp(16'h1234, 8'h05, 4, 2);
    begin
      automatic int target = done_seen + 1;
      exp_code_q.push_back(8);
      exp_rsp_q.push_back(rsp_mem[2]); exp_rsp_q.push_back(rsp_mem[3]);
      @(negedge clk);
      task_req_dw = 0; task_rsp_cap = 4; task_valid = 1'b1;
      while (!task_ready) @(negedge clk);
      @(negedge clk); task_valid = 1'b0;
      repeat (80) @(negedge clk);
      check(going && stat_since_go == 0, "R12 no status read before interrupt", stat_since_go, 0);
      check(last_ctrl == 32'h8000_0002, "R12 go with interrupt enable", last_ctrl, 32'h8000_0002);
      mb_irq = 1'b1; @(negedge clk); mb_irq = 1'b0;
      repeat (150) @(negedge clk);
      check(done_seen == target, "R12 completion after interrupt", done_seen, target);
    end
    use_irq = 1'b0;

    // R9 recovery timeout -> dead, R10 rejection
    err_flag = 1'b1; abort_busy = 100000;
    run_task(16'h1234, 8'h05, 0, 2, -5, 0);
    begin
      automatic int lim = 0;
      while (!dead && lim < 1500) begin @(negedge clk); lim++; end
    end
    check(dead == 1'b1, "R9 dead after recovery timeout", dead, 1);
    wait_idle("R9 idle after dead");
    begin
      automatic int o = ops;
      run_task(16'h1234, 8'h05, 0, 2, -5, 0);
      check(ops == o, "R10 no bus operation when dead", ops, o);
    end

    // R1 reset clears dead
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; busy_left = 0; abort_busy = 0; err_flag = 0;
    @(negedge clk);
    check(dead == 1'b0, "R1 dead cleared by reset", dead, 0);
    check(exp_code_q.size() == 0, "R4-R12 all results seen", exp_code_q.size(), 0);
    summary();
  end
endmodule